// File: doc/BRIEF.md
# Prescaled 8-bit PWM Channel

This block drives one pulse-width modulated output, intended for dimming a display backlight. A power-of-two prescaler slows the system clock by a factor picked from a 4-bit select (1 up to 32768), and a 256-step period counter advances once per prescaled tick. An 8-bit duty code sets how many ticks at the start of each period the output is high. A second function, picked by a mode bit, replaces the PWM waveform with a fixed clock at one sixteenth of the input clock. Two instances serve two channels.

While the channel is disabled or the sleep input is high, the output rests at a programmable idle level. The idle level is used only in PWM mode. All inputs are plain control levels; there is no streaming interface, so no valid/ready handshake applies. The duty and prescale settings are captured when the channel starts and again at every period wrap, so that software can change them at any time without producing a glitch in the middle of a period.

Top module: `pwm_chan`

## Requirements
- R1: After reset the channel is stopped and `pwm_o` equals `idle_lvl` when `fix_sel` is 0.
- R2: With prescale select k (0..15), each duty step lasts 2^k system clock cycles, so one period lasts 256·2^k cycles; k = 15 gives 32768 cycles per step.
- R3: With duty code n, `pwm_o` is high for the first (n+1)·2^k cycles of each period and low for the rest; code 8'hFF keeps the output high for the whole period.
- R4: In PWM mode (`fix_sel` = 0), one cycle after the edge that sees `en` low or `sleep` high, `pwm_o` equals `idle_lvl` and stays there while stopped.
- R5: With `fix_sel` = 1 and the channel running, `pwm_o` is a clock with a period of 16 system cycles, low for the first 8 cycles after start; `duty` and `div_sel` have no effect on it.
- R6: With `fix_sel` = 1 and the channel stopped, `pwm_o` is low whatever `idle_lvl` is.
- R7: `duty` and `div_sel` are captured only at start and at the wrap from step 255 to step 0; a change in mid-period first shows in the next period.
- R8: The channel starts on the first clock edge that sees `en` high and `sleep` low after being stopped; both counters restart, and from the next cycle the output is at step 0 of a fresh period (high in PWM mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| sleep | input | 1 | Sleep request; stops the channel like `en` low |
| idle_lvl | input | 1 | Output level while stopped in PWM mode |
| fix_sel | input | 1 | 0: PWM waveform, 1: fixed divide-by-16 clock |
| div_sel | input | 4 | Prescale exponent k, divide by 2^k |
| duty | input | 8 | Duty code n, high for (n+1)/256 of a period |
| pwm_o | output | 1 | Channel output |

## Verification
A wrong step counter or a lost duty capture shows at `pwm_o` within one period as a high time that differs from (n+1)·2^k cycles, or as a high phase that does not begin at the start of a period. A prescaler that fails to clear on start shifts the first falling edge by up to 2^k cycles, so it shows within the first period after enabling. A start or stop flag that lags or sticks shows one cycle after the enabling or stopping edge, as the idle level where the waveform should begin, or as the waveform where the idle level should be.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DUTY_W = 8;
  localparam int SEL_W  = 4;
  localparam int FIX_W  = 4;
  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  generate
    if (PRE_W == 0) begin : g_none
      assign tick = run;
    end else begin : g_cnt
      logic [PRE_W-1:0] cnt;
      logic [PRE_W:0]   lim_w;
      logic [PRE_W-1:0] lim;

      // limit is 2^sel - 1; computed one bit wider so sel at its top value wraps cleanly
      assign lim_w = ({{PRE_W{1'b0}}, 1'b1} << sel) - 1'b1;
      assign lim   = lim_w[PRE_W-1:0];
      assign tick  = run && (cnt == lim);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (start)   cnt <= '0;
        else if (run)     cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int DUTY_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [SEL_W-1:0]  sel_in,
  output logic [DUTY_W-1:0] pos,
  output logic [DUTY_W-1:0] duty_lat,
  output logic [SEL_W-1:0]  sel_lat,
  output logic              hi
);
  logic wrap;
  assign wrap = tick && (&pos);
  assign hi   = (pos <= duty_lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      duty_lat <= '0;
      sel_lat  <= '0;
    end else if (start) begin
      pos      <= '0;
      duty_lat <= duty_in;
      sel_lat  <= sel_in;
    end else if (tick) begin
      pos <= pos + 1'b1;
      if (wrap) begin
        duty_lat <= duty_in;
        sel_lat  <= sel_in;
      end
    end
  end
endmodule

// File: rtl/pwm_fixdiv.sv
module pwm_fixdiv #(
  parameter int FIX_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic clk_out
);
  logic [FIX_W-1:0] cnt;
  assign clk_out = cnt[FIX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int DW = DUTY_W,
  parameter int SW = SEL_W,
  parameter int FW = FIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sleep,
  input  logic          idle_lvl,
  input  logic          fix_sel,
  input  logic [SW-1:0] div_sel,
  input  logic [DW-1:0] duty,
  output logic          pwm_o
);
  logic          active, run_q, start, tick, hi, fix_clk;
  logic [DW-1:0] pos, duty_lat;
  logic [SW-1:0] sel_lat;

  assign active = en && !sleep;
  assign start  = active && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= active;
  end

  pwm_prescale #(.SEL_W(SW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(start),
    .sel(sel_lat), .tick(tick)
  );

  pwm_period #(.DUTY_W(DW), .SEL_W(SW)) u_per (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .duty_in(duty), .sel_in(div_sel),
    .pos(pos), .duty_lat(duty_lat), .sel_lat(sel_lat), .hi(hi)
  );

  pwm_fixdiv #(.FIX_W(FW)) u_fix (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(start), .clk_out(fix_clk)
  );

  always_comb begin
    if (run_q) pwm_o = fix_sel ? fix_clk : hi;
    else       pwm_o = fix_sel ? 1'b0 : idle_lvl;
  end
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sleep,
  input logic          idle_lvl,
  input logic          fix_sel,
  input logic          pwm_o,
  input logic          run_q,
  input logic          tick,
  input logic [DW-1:0] pos,
  input logic [DW-1:0] duty_lat
);
  // R4: stopped in PWM mode shows the idle level
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(en && !sleep)) && !fix_sel) |-> (pwm_o == idle_lvl));

  // R6: stopped in fixed-clock mode is low
  a_r6_fix_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(en && !sleep)) && fix_sel) |-> !pwm_o);

  // R7: captured duty holds between period wraps
  a_r7_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(duty_lat));

  // R3: step counter wraps from the last step to step 0
  a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && (&pos)) |=> (pos == '0));

  // R3: full-scale code keeps the output high
  a_r3_full_code_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !fix_sel && (&duty_lat)) |-> pwm_o);

  // R8: a fresh start opens the period high in PWM mode
  a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en && !sleep) && !$past(run_q) && !fix_sel) |-> pwm_o);
endmodule

bind pwm_chan pwm_chan_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep), .idle_lvl(idle_lvl),
  .fix_sel(fix_sel), .pwm_o(pwm_o), .run_q(run_q), .tick(tick),
  .pos(pos), .duty_lat(duty_lat)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, sleep = 1'b0, idle_lvl = 1'b0, fix_sel = 1'b0;
  logic [3:0] div_sel = 4'd0;
  logic [7:0] duty = 8'd0;
  logic       pwm_o;

  int ntest = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwm_chan u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep), .idle_lvl(idle_lvl),
    .fix_sel(fix_sel), .div_sel(div_sel), .duty(duty), .pwm_o(pwm_o)
  );

  // {div_sel, duty}
  localparam logic [11:0] VEC [6] = '{
    {4'd0, 8'h00}, {4'd0, 8'h7F}, {4'd0, 8'hFF},
    {4'd1, 8'h03}, {4'd2, 8'h10}, {4'd3, 8'hC8}
  };

  task automatic chk(input string req, input int act, input int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stop_chan();
    @(negedge clk); en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // enable at a negedge; returns positioned at the negedge holding sample 0
  task automatic start_chan();
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  endtask

  initial begin
    #700000;
    nfail++; ntest++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int highs, first_low, per, k;
    repeat (3) @(negedge clk);
    // R1: reset state shows idle level
    chk("R1 reset idle low", pwm_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_lvl = 1'b1; #1;
    chk("R1 idle high after reset", pwm_o, 1);
    idle_lvl = 1'b0;

    // R2 R3 R8: vector walk
    foreach (VEC[v]) begin
      stop_chan();
      div_sel = VEC[v][11:8];
      duty    = VEC[v][7:0];
      k   = int'(VEC[v][11:8]);
      per = 256 << k;
      start_chan();
      highs = 0; first_low = per;
      for (int i = 0; i < per; i++) begin
        if (pwm_o) highs++;
        else if (first_low == per) first_low = i;
        @(negedge clk);
      end
      chk("R3 high count", highs, (int'(VEC[v][7:0]) + 1) << k);
      chk("R2 R8 first low cycle", first_low,
          (VEC[v][7:0] == 8'hFF) ? per : ((int'(VEC[v][7:0]) + 1) << k));
    end

    // R7: mid-period duty change takes effect at the wrap
    stop_chan();
    div_sel = 4'd0; duty = 8'd3;
    start_chan();
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_o) highs++;
      if (i == 10) duty = 8'd200;
      @(negedge clk);
    end
    chk("R7 old duty kept this period", highs, 4);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_o) highs++;
      @(negedge clk);
    end
    chk("R7 new duty next period", highs, 201);

    // R4: sleep and disable show idle level
    duty = 8'hFF; idle_lvl = 1'b0;
    stop_chan();
    start_chan();
    chk("R8 running high", pwm_o, 1);
    sleep = 1'b1;
    @(negedge clk);
    chk("R4 sleep idle low", pwm_o, 0);
    idle_lvl = 1'b1; #1;
    chk("R4 sleep idle high", pwm_o, 1);
    sleep = 1'b0; idle_lvl = 1'b0;
    @(negedge clk);
    chk("R8 restart after sleep", pwm_o, 1);
    en = 1'b0; idle_lvl = 1'b1;
    @(negedge clk);
    chk("R4 disabled idle high", pwm_o, 1);

    // R5 R6: fixed clock mode, settings ignored
    for (int m = 0; m < 2; m++) begin
      stop_chan();
      fix_sel = 1'b1;
      idle_lvl = 1'b1; #1;
      chk("R6 fixed mode stopped low", pwm_o, 0);
      div_sel = (m == 0) ? 4'd0 : 4'd15;
      duty    = (m == 0) ? 8'h00 : 8'hFF;
      start_chan();
      first_low = 0;
      for (int i = 0; i < 48; i++) begin
        if (pwm_o != (((i / 8) % 2) == 1)) first_low++;
        @(negedge clk);
      end
      chk("R5 fixed 16-cycle clock mismatches", first_low, 0);
    end
    fix_sel = 1'b0;

    // R2: largest prescale, one step spans 32768 cycles
    stop_chan();
    div_sel = 4'd15; duty = 8'h00; idle_lvl = 1'b0;
    start_chan();
    repeat (32767) @(negedge clk);
    chk("R2 last cycle of step 0 high", pwm_o, 1);
    @(negedge clk);
    chk("R2 step 1 low", pwm_o, 0);

    finish_run();
  end
endmodule